// File: doc/BRIEF.md
# Local Oscillator Retune Write Sequencer

This block turns a single retune command into a run of serial register writes that move the receive and transmit local oscillators to a new frequency. A command carries twelve register slots: six receive-path PLL registers in slots 0 to 5 and six transmit-path PLL registers in slots 6 to 11. Each slot has its own 7-bit register address and 8-bit value, and a 12-bit change mask marks which slots must be written. Slots whose mask bit is clear are skipped, so a small frequency step costs only the writes it needs.

The sequencer runs in the design clock domain and sits in front of an SPI master that does the serialization. For each selected slot it presents a 16-bit frame and pulses a start request. It then waits for the master's busy flag to rise and fall before it moves on. After the last write completes it pulses a done flag. It also reports the elapsed time in design-clock cycles, counted from the first start request to the cycle in which the final busy deassertion is seen. A decision engine in user logic can therefore retune with a fixed, known latency and without a processor in the path.

Top module: `lo_retune_seq`

## Requirements
- R1: After reset `seqIdle` is 1, `spiStart` and `retuneDone` are 0 and `latency` is 0.
- R2: Every issued frame has bit 15 set to 1 (write). Bits 14:8 hold the slot's address, taken from `cmdAddr[7*i +: 7]`, and bits 7:0 hold the slot's value, taken from `cmdData[8*i +: 8]`.
- R3: Frames are issued in ascending slot order. The receive slots 0 to 5 therefore go out before the transmit slots 6 to 11.
- R4: Exactly one frame is issued for each set bit of `cmdMask`. A slot whose mask bit is 0 is never issued.
- R5: `spiStart` is a one-cycle pulse. A new start is never raised while `spiBusy` was high in the previous cycle, and never before the previous write's busy has risen and fallen.
- R6: The next start follows the cycle in which busy is first seen low after a write, with no further gap. Each write therefore occupies busy-length plus 2 cycles.
- R7: `latency` equals the number of cycles from the first start to the cycle in which the last busy deassertion is sampled. With a master that holds busy for N cycles starting the cycle after start, k writes give k*(N+2)-1.
- R8: A command with an all-zero mask issues no frame. It raises `retuneDone` in the cycle after acceptance with `latency` equal to 0.
- R9: `retuneDone` is high for exactly one cycle per accepted command. It rises in the cycle after the final busy deassertion is sampled.
- R10: `latency` holds its value from completion until the next command is accepted. A `cmdValid` seen while `seqIdle` is 0 is ignored and does not change the issued frames.
- R11: `seqIdle` is 1 exactly when a command would be accepted. It is 0 during a run and in the cycle `retuneDone` is high, and no start is raised while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Retune command present, taken when seqIdle is 1 |
| cmdMask | input | 12 | Per-slot change mask, bit i selects slot i |
| cmdAddr | input | 84 | Seven-bit register address per slot, slot i at bits 7*i+6:7*i |
| cmdData | input | 96 | Eight-bit register value per slot, slot i at bits 8*i+7:8*i |
| spiStart | output | 1 | One-cycle start request to the SPI master |
| spiFrame | output | 16 | Write frame for the SPI master, valid with spiStart |
| spiBusy | input | 1 | Busy flag from the SPI master |
| retuneDone | output | 1 | One-cycle pulse when the retune completes |
| latency | output | 16 | Elapsed design-clock cycles of the last retune |
| seqIdle | output | 1 | Sequencer ready for a new command |

## Verification
Two events can meet in one cycle. The final busy deassertion can coincide with the arrival of a fresh command, and at that point the sequencer is still running and must drop the command. The bench waits until the last write's busy falls and pulses `cmdValid` with a new mask at the edge that completes the run. It then judges that the done pulse and the latency match the original run, and that no extra frame appears afterwards. A second case, the done pulse falling in the same cycle as a new zero-mask command, is covered by gating acceptance with `seqIdle`. The bench checks this through the single-cycle shape of `retuneDone`.

// File: rtl/lo_retune_pkg.sv
package lo_retune_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_ACK   = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic load;   // capture command slots, clear latency count
    logic issue;  // current lowest pending slot is being sent
    logic count;  // advance latency counter this cycle
  } seq_strobe_t;

endpackage

// File: rtl/lo_retune_ctrl.sv
module lo_retune_ctrl
  import lo_retune_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdEmpty,
  input  logic        morePending,
  input  logic        spiBusy,
  output seq_strobe_t strb,
  output logic        spiStart,
  output logic        retuneDone,
  output logic        seqIdle
);

  seq_state_t stateQ, stateD;
  logic       doneQ, doneD;
  logic       accept;
  logic       finalEdge;

  assign seqIdle    = (stateQ == ST_IDLE) && !doneQ;
  assign accept     = seqIdle && cmdValid;
  assign spiStart   = (stateQ == ST_ISSUE);
  assign finalEdge  = (stateQ == ST_DRAIN) && !spiBusy && !morePending;
  assign retuneDone = doneQ;

  always_comb begin
    stateD = stateQ;
    doneD  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          if (cmdEmpty) doneD  = 1'b1;
          else          stateD = ST_ISSUE;
        end
      end
      ST_ISSUE: stateD = ST_ACK;
      ST_ACK: begin
        if (spiBusy) stateD = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!spiBusy) begin
          if (morePending) begin
            stateD = ST_ISSUE;
          end else begin
            stateD = ST_IDLE;
            doneD  = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.load  = accept;
    strb.issue = spiStart;
    strb.count = (stateQ != ST_IDLE) && !finalEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    spiStart |=> !spiStart); // R5
  AST_START_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiStart) |-> !$past(spiBusy)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    retuneDone |=> !retuneDone); // R9
  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    seqIdle |-> !spiStart); // R11
  AST_DONE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    retuneDone |-> !seqIdle); // R11

endmodule

// File: rtl/lo_retune_dp.sv
module lo_retune_dp
  import lo_retune_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int LAT_W     = 16,
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int FRAME_W  = 1 + ADDR_W + DATA_W
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  seq_strobe_t                 strb,
  input  logic [NUM_SLOTS-1:0]        cmdMask,
  input  logic [NUM_SLOTS*ADDR_W-1:0] cmdAddr,
  input  logic [NUM_SLOTS*DATA_W-1:0] cmdData,
  output logic                        cmdEmpty,
  output logic                        morePending,
  output logic [FRAME_W-1:0]          spiFrame,
  output logic [LAT_W-1:0]            latency
);

  logic [NUM_SLOTS-1:0] pendQ;
  logic [ADDR_W-1:0]    addrQ [NUM_SLOTS];
  logic [DATA_W-1:0]    dataQ [NUM_SLOTS];
  logic [SEL_W-1:0]     sel;
  logic [NUM_SLOTS-1:0] selHot;
  logic [LAT_W-1:0]     latQ;

  assign cmdEmpty    = (cmdMask == '0);
  assign morePending = |pendQ;

  // lowest set pending bit wins: receive slots precede transmit slots
  always_comb begin
    sel = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pendQ[i]) sel = SEL_W'(i);
    end
  end

  always_comb begin
    selHot = '0;
    selHot[sel] = pendQ[sel];
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ[g] <= '0;
        dataQ[g] <= '0;
      end else if (strb.load) begin
        addrQ[g] <= cmdAddr[g*ADDR_W +: ADDR_W];
        dataQ[g] <= cmdData[g*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
    end else if (strb.load) begin
      pendQ <= cmdMask;
    end else if (strb.issue) begin
      pendQ <= pendQ & ~selHot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latQ <= '0;
    end else if (strb.load) begin
      latQ <= '0;
    end else if (strb.count && (latQ != '1)) begin
      latQ <= latQ + 1'b1;
    end
  end

  assign spiFrame = {1'b1, addrQ[sel], dataQ[sel]};
  assign latency  = latQ;

  AST_PENDING_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && !strb.load) |=> ($countones(pendQ) + 1 == $past($countones(pendQ)))); // R4
  AST_ISSUE_HAS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (pendQ != '0)); // R4
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.count) |=> $stable(latQ)); // R10

endmodule

// File: rtl/lo_retune_seq.sv
module lo_retune_seq
  import lo_retune_pkg::*;
#(
  parameter int SLOTS_PER_PATH = 6,
  parameter int ADDR_W         = 7,
  parameter int DATA_W         = 8,
  parameter int LAT_W          = 16,
  localparam int NUM_SLOTS     = 2 * SLOTS_PER_PATH,
  localparam int FRAME_W       = 1 + ADDR_W + DATA_W
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdValid,
  input  logic [NUM_SLOTS-1:0]        cmdMask,
  input  logic [NUM_SLOTS*ADDR_W-1:0] cmdAddr,
  input  logic [NUM_SLOTS*DATA_W-1:0] cmdData,
  output logic                        spiStart,
  output logic [FRAME_W-1:0]          spiFrame,
  input  logic                        spiBusy,
  output logic                        retuneDone,
  output logic [LAT_W-1:0]            latency,
  output logic                        seqIdle
);

  seq_strobe_t strb;
  logic        cmdEmpty;
  logic        morePending;

  lo_retune_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdEmpty    (cmdEmpty),
    .morePending (morePending),
    .spiBusy     (spiBusy),
    .strb        (strb),
    .spiStart    (spiStart),
    .retuneDone  (retuneDone),
    .seqIdle     (seqIdle)
  );

  lo_retune_dp #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LAT_W     (LAT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cmdMask     (cmdMask),
    .cmdAddr     (cmdAddr),
    .cmdData     (cmdData),
    .cmdEmpty    (cmdEmpty),
    .morePending (morePending),
    .spiFrame    (spiFrame),
    .latency     (latency)
  );

endmodule

// File: tb/lo_retune_seq_test.sv
module lo_retune_seq_test;

  localparam int NS = 12;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic [11:0]  cmdMask = '0;
  logic [83:0]  cmdAddr;
  logic [95:0]  cmdData;
  logic         spiStart;
  logic [15:0]  spiFrame;
  logic         spiBusy;
  logic         retuneDone;
  logic [15:0]  latency;
  logic         seqIdle;

  int tests = 0;
  int fails = 0;
  int busyLen = 4;
  int busyCnt = 0;
  int fc = 0;
  logic [15:0] frames [16];
  bit startWhileBusy = 0;
  bit wdExpired = 0;

  always #10 clk = ~clk;

  assign spiBusy = (busyCnt != 0);

  lo_retune_seq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdMask(cmdMask),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .spiStart(spiStart),
    .spiFrame(spiFrame), .spiBusy(spiBusy), .retuneDone(retuneDone),
    .latency(latency), .seqIdle(seqIdle)
  );

  // SPI master model: busy for busyLen cycles starting the cycle after start
  always @(posedge clk) begin
    if (spiStart) begin
      if (spiBusy) startWhileBusy <= 1'b1;
      busyCnt <= busyLen;
      if (fc < 16) frames[fc] <= spiFrame;
      fc <= fc + 1;
    end else if (busyCnt > 0) begin
      busyCnt <= busyCnt - 1;
    end
  end

  // stimulus vectors: {mask, busy length}
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {12'hFFF, 8'd30},
    {12'h000 | 12'h041, 8'd5},
    {12'h800, 8'd3},
    {12'h0A5, 8'd1},
    {12'hF00, 8'd7},
    {12'h03F, 8'd2}
  };

  function automatic logic [6:0] slotAddr(int i, int salt);
    return 7'((i * 5 + salt + 3) & 7'h7F);
  endfunction
  function automatic logic [7:0] slotData(int i, int salt);
    return 8'((i * 29 + salt * 11 + 8'h40) & 8'hFF);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic loadSlots(int salt);
    for (int i = 0; i < NS; i++) begin
      cmdAddr[i*7 +: 7] = slotAddr(i, salt);
      cmdData[i*8 +: 8] = slotData(i, salt);
    end
  endtask

  task automatic sendCmd(logic [11:0] m);
    @(negedge clk);
    while (!seqIdle) @(negedge clk);
    fc = 0;
    cmdMask  = m;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!retuneDone && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkFrames(logic [11:0] m, int salt, string tag);
    int k = 0;
    check(fc == $countones(m), "R4", {tag, " frame count"}, fc, $countones(m));
    for (int i = 0; i < NS; i++) begin
      if (m[i] && k < 16 && k < fc) begin
        check(frames[k] == {1'b1, slotAddr(i, salt), slotData(i, salt)}, "R2/R3",
              {tag, " frame content/order"}, int'(frames[k]),
              int'({1'b1, slotAddr(i, salt), slotData(i, salt)}));
        k++;
      end
    end
  endtask

  initial begin
    cmdAddr = '0;
    cmdData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(seqIdle == 1'b1 && spiStart == 1'b0 && retuneDone == 1'b0 && latency == 16'd0,
          "R1", "reset outputs", int'({seqIdle, spiStart, retuneDone}), 4);
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [11:0] m;
      int n;
      int k;
      m = VEC[v][19:8];
      n = int'(VEC[v][7:0]);
      busyLen = n;
      k = $countones(m);
      loadSlots(v);
      sendCmd(m);
      check(seqIdle == 1'b0, "R11", "busy during run", int'(seqIdle), 0);
      waitDone();
      check(retuneDone == 1'b1, "R9", "done raised", int'(retuneDone), 1);
      check(latency == 16'(k * (n + 2) - 1), "R6/R7", "latency", int'(latency), k * (n + 2) - 1);
      checkFrames(m, v, "table");
      @(negedge clk);
      check(retuneDone == 1'b0, "R9", "done one cycle", int'(retuneDone), 0);
      repeat (3) @(negedge clk);
      check(latency == 16'(k * (n + 2) - 1), "R10", "latency held", int'(latency), k * (n + 2) - 1);
    end
    check(!startWhileBusy, "R5", "no start while busy", int'(startWhileBusy), 0);

    // R8 zero mask
    loadSlots(9);
    @(negedge clk);
    fc = 0;
    cmdMask = 12'h000;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(retuneDone == 1'b1 && latency == 16'd0, "R8", "zero mask done", int'(latency), 0);
    check(seqIdle == 1'b0, "R11", "not idle with done", int'(seqIdle), 0);
    @(negedge clk);
    check(retuneDone == 1'b0 && fc == 0, "R8", "zero mask no frame", fc, 0);

    // R10 command during run ignored, including at the completion edge
    busyLen = 6;
    loadSlots(4);
    sendCmd(12'h201);
    repeat (3) @(negedge clk);
    cmdMask = 12'hFFF; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!(fc == 2 && !spiBusy)) @(negedge clk);
    cmdMask = 12'h001; cmdValid = 1'b1;   // lands on final completion edge
    @(negedge clk);
    cmdValid = 1'b0;
    check(retuneDone == 1'b1, "R9", "done at overlap", int'(retuneDone), 1);
    check(latency == 16'(2 * 8 - 1), "R7", "overlap latency", int'(latency), 15);
    repeat (12) @(negedge clk);
    checkFrames(12'h201, 4, "overlap");
    check(fc == 2 && latency == 16'd15, "R10", "late command ignored", fc, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    wdExpired = 1;
    tests++;
    fails++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule